// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic unit of a small accumulator-style controller. Each operation combines the working register W with a register operand R or an 8-bit immediate. It returns the result, a write strobe, and a destination select that picks either W or the register. It also returns new carry, half-carry and zero flags, each with its own update strobe, and a skip request for the conditional-skip forms. The unit stores no registers of its own apart from one output stage. The surrounding controller supplies the operands and the incoming carry, and it commits the result and the flags.

All arithmetic runs through one shared adder. Addition is W + R. Subtraction is R + ~W + 1, so its carry means "no borrow". Increment and decrement add to R either zero with a carry in of one, or all ones. The half carry is the carry out of bit 3 of that same addition. Logic, rotate, nibble swap, complement, bit set and bit clear run beside the adder, and a single multiplexer selects among them. The result appears one clock after the operation is presented.

Top module: `acc_alu`

## Requirements
- R1: The 6-bit operation code is numbered as follows: 0 ADD, 1 SUB, 2 INC, 3 DEC, 4 INCSZ, 5 DECSZ, 6 AND, 7 IOR, 8 XOR, 9 ANDI, 10 IORI, 11 XORI, 12 COM, 13 RRR, 14 RLR, 15 SWAP, 16 CLRW, 17 CLRR, 18 BCLR, 19 BSET, 20 BTSC, 21 BTSS, 22 MOV, 23 LDI, 24 STW. An operation presented with in_valid high at a clock edge appears on the outputs after that edge, with out_valid high.
- R2: ADD produces W + R and updates all three flags. C is the carry out of bit 7, HC is the carry out of bit 3, and Z is 1 when the 8-bit result is zero.
- R3: SUB produces R + ~W + 1 and updates all three flags. C and HC are the carries out of bit 7 and bit 3 of that sum, and Z is 1 when the result is zero.
- R4: INC (R + 1) and DEC (R - 1) update only Z. INCSZ and DECSZ produce the same results but update no flag, and they raise skip_o when the result is zero.
- R5: AND, IOR and XOR combine W with R. ANDI, IORI and XORI combine W with the immediate. COM produces ~R and MOV produces R. All of these update only Z. The immediate forms always write W (to_reg_o = 0), whatever the target bit.
- R6: RRR shifts R right, with the incoming carry entering bit 7 and bit 0 going to C. RLR shifts R left, with the incoming carry entering bit 0 and bit 7 going to C. Only C is updated.
- R7: SWAP exchanges bits 3:0 with bits 7:4 of R and updates no flag.
- R8: CLRW and CLRR produce zero and set Z. CLRW always writes W and CLRR always writes the register.
- R9: BCLR and BSET clear or set the bit of R that bit_i selects, and they always write the register. LDI writes the immediate to W, and STW writes W to the register. None of these four updates a flag.
- R10: BTSC raises skip_o when the selected bit of R is 0, and BTSS raises it when that bit is 1. Neither writes (wr_o = 0, to_reg_o = 0), and res_o shows R.
- R11: ADD, SUB, INC, DEC, INCSZ, DECSZ, AND, IOR, XOR, COM, RRR, RLR, SWAP and MOV write the register when tgt_i is 1 and W when tgt_i is 0.
- R12: When C is not updated, c_o repeats the incoming carry. When HC or Z is not updated, that output is 0. An operation code above 24 produces res_o = 0 and no write, no flag update and no skip.
- R13: While reset is active, every output is 0. A cycle with in_valid low clears out_valid, wr_o, skip_o and all update strobes in the following cycle, and res_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_i | input | 6 | Operation code (R1) |
| tgt_i | input | 1 | Target bit: 1 selects the register, 0 selects W |
| w_i | input | 8 | Working register value |
| r_i | input | 8 | Register operand |
| imm_i | input | 8 | Immediate operand |
| bit_i | input | 3 | Bit position for set, clear and test |
| c_i | input | 1 | Incoming carry flag |
| out_valid | output | 1 | The result registers hold a fresh operation |
| res_o | output | 8 | Result |
| wr_o | output | 1 | The result is to be written |
| to_reg_o | output | 1 | Destination: 1 is the register, 0 is W |
| c_o | output | 1 | Carry flag value |
| hc_o | output | 1 | Half-carry flag value |
| z_o | output | 1 | Zero flag value |
| c_upd_o | output | 1 | Carry is to be updated |
| hc_upd_o | output | 1 | Half carry is to be updated |
| z_upd_o | output | 1 | Zero is to be updated |
| skip_o | output | 1 | Skip the next instruction |

## Verification
Errors in operand selection or carry-in selection show up in the very next cycle. They appear as a wrong result or as a wrong C or HC on the operand corners 0x00, 0x0F, 0x80 and 0xFF. Addition, subtraction and the rotates each use a different carry source, so each of those errors is visible on its own. A wrongly decoded update strobe or destination appears on the same output cycle, in the strobe and target columns of the vector table. A stale output-stage strobe appears one cycle after in_valid falls.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

   localparam int OP_W = 6;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 6'd0,
      OP_SUB   = 6'd1,
      OP_INC   = 6'd2,
      OP_DEC   = 6'd3,
      OP_INCSZ = 6'd4,
      OP_DECSZ = 6'd5,
      OP_AND   = 6'd6,
      OP_IOR   = 6'd7,
      OP_XOR   = 6'd8,
      OP_ANDI  = 6'd9,
      OP_IORI  = 6'd10,
      OP_XORI  = 6'd11,
      OP_COM   = 6'd12,
      OP_RRR   = 6'd13,
      OP_RLR   = 6'd14,
      OP_SWAP  = 6'd15,
      OP_CLRW  = 6'd16,
      OP_CLRR  = 6'd17,
      OP_BCLR  = 6'd18,
      OP_BSET  = 6'd19,
      OP_BTSC  = 6'd20,
      OP_BTSS  = 6'd21,
      OP_MOV   = 6'd22,
      OP_LDI   = 6'd23,
      OP_STW   = 6'd24
   } op_e;

   typedef struct packed {
      logic wr;
      logic to_reg;
      logic c_upd;
      logic hc_upd;
      logic z_upd;
      logic c;
      logic hc;
      logic z;
      logic skip;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 8,
   parameter int HC_BIT = 4,
   parameter int RIPPLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             hcout_o
);

   generate
      if (RIPPLE != 0) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
            assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
         assign cout_o  = cy[WIDTH];
         assign hcout_o = cy[HC_BIT];
      end else begin : g_behav
         logic [WIDTH:0]  full;
         logic [HC_BIT:0] low;
         always_comb begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
            low  = {1'b0, a_i[HC_BIT-1:0]} + {1'b0, b_i[HC_BIT-1:0]}
                 + {{HC_BIT{1'b0}}, cin_i};
         end
         assign sum_o   = full[WIDTH-1:0];
         assign cout_o  = full[WIDTH];
         assign hcout_o = low[HC_BIT];
      end
   endgenerate

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] rr_o,
   output logic             rr_c_o,
   output logic [WIDTH-1:0] rl_o,
   output logic             rl_c_o,
   output logic [WIDTH-1:0] swap_o
);

   localparam int HALF = WIDTH / 2;

   assign rr_o   = {cin_i, val_i[WIDTH-1:1]};
   assign rr_c_o = val_i[0];
   assign rl_o   = {val_i[WIDTH-2:0], cin_i};
   assign rl_c_o = val_i[WIDTH-1];

   generate
      for (genvar i = 0; i < HALF; i++) begin : g_swap
         assign swap_o[i]      = val_i[i+HALF];
         assign swap_o[i+HALF] = val_i[i];
      end
   endgenerate

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
   parameter int WIDTH = 8,
   localparam int BIT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic [BIT_W-1:0] sel_i,
   output logic [WIDTH-1:0] set_o,
   output logic [WIDTH-1:0] clr_o,
   output logic             bit_o
);

   logic [WIDTH-1:0] mask;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_dec
         assign mask[i] = (sel_i == BIT_W'(i));
      end
   endgenerate

   assign set_o = val_i | mask;
   assign clr_o = val_i & ~mask;
   assign bit_o = |(val_i & mask);

endmodule

// File: rtl/alu_core.sv
module alu_core
   import accalu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int HC_BIT = 4,
   parameter int RIPPLE = 0,
   localparam int BIT_W = $clog2(WIDTH)
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic             tgt_i,
   input  logic [WIDTH-1:0] w_i,
   input  logic [WIDTH-1:0] r_i,
   input  logic [WIDTH-1:0] imm_i,
   input  logic [BIT_W-1:0] bit_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] res_o,
   output ctl_t             ctl_o
);

   logic [WIDTH-1:0] add_a, add_b, sum;
   logic             add_ci, cout, hcout;
   logic [WIDTH-1:0] rr, rl, sw, bset, bclr;
   logic             rr_c, rl_c, bitv;
   logic             c_sel;

   alu_adder #(.WIDTH(WIDTH), .HC_BIT(HC_BIT), .RIPPLE(RIPPLE)) u_add (
      .a_i(add_a), .b_i(add_b), .cin_i(add_ci),
      .sum_o(sum), .cout_o(cout), .hcout_o(hcout)
   );

   alu_shift #(.WIDTH(WIDTH)) u_shf (
      .val_i(r_i), .cin_i(c_i),
      .rr_o(rr), .rr_c_o(rr_c), .rl_o(rl), .rl_c_o(rl_c), .swap_o(sw)
   );

   alu_bitops #(.WIDTH(WIDTH)) u_bit (
      .val_i(r_i), .sel_i(bit_i),
      .set_o(bset), .clr_o(bclr), .bit_o(bitv)
   );

   // operand steering for the shared adder
   always_comb begin
      add_a  = r_i;
      add_b  = '0;
      add_ci = 1'b0;
      unique case (op_e'(op_i))
         OP_ADD:            begin add_a = w_i; add_b = r_i; end
         OP_SUB:            begin add_b = ~w_i; add_ci = 1'b1; end
         OP_INC, OP_INCSZ:  add_ci = 1'b1;
         OP_DEC, OP_DECSZ:  add_b = '1;
         default:           ;
      endcase
   end

   always_comb begin
      res_o = '0;
      ctl_o = CTL_IDLE;
      c_sel = c_i;
      unique case (op_e'(op_i))
         OP_ADD, OP_SUB: begin
            res_o = sum; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i;
            ctl_o.c_upd = 1'b1; ctl_o.hc_upd = 1'b1; ctl_o.z_upd = 1'b1;
            c_sel = cout;
         end
         OP_INC, OP_DEC: begin
            res_o = sum; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.z_upd = 1'b1;
         end
         OP_INCSZ, OP_DECSZ: begin
            res_o = sum; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i;
            ctl_o.skip = (sum == '0);
         end
         OP_AND: begin res_o = w_i & r_i; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.z_upd = 1'b1; end
         OP_IOR: begin res_o = w_i | r_i; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.z_upd = 1'b1; end
         OP_XOR: begin res_o = w_i ^ r_i; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.z_upd = 1'b1; end
         OP_ANDI: begin res_o = w_i & imm_i; ctl_o.wr = 1'b1; ctl_o.z_upd = 1'b1; end
         OP_IORI: begin res_o = w_i | imm_i; ctl_o.wr = 1'b1; ctl_o.z_upd = 1'b1; end
         OP_XORI: begin res_o = w_i ^ imm_i; ctl_o.wr = 1'b1; ctl_o.z_upd = 1'b1; end
         OP_COM: begin res_o = ~r_i; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.z_upd = 1'b1; end
         OP_MOV: begin res_o = r_i; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.z_upd = 1'b1; end
         OP_RRR: begin
            res_o = rr; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.c_upd = 1'b1; c_sel = rr_c;
         end
         OP_RLR: begin
            res_o = rl; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; ctl_o.c_upd = 1'b1; c_sel = rl_c;
         end
         OP_SWAP: begin res_o = sw; ctl_o.wr = 1'b1; ctl_o.to_reg = tgt_i; end
         OP_CLRW: begin ctl_o.wr = 1'b1; ctl_o.z_upd = 1'b1; end
         OP_CLRR: begin ctl_o.wr = 1'b1; ctl_o.to_reg = 1'b1; ctl_o.z_upd = 1'b1; end
         OP_BCLR: begin res_o = bclr; ctl_o.wr = 1'b1; ctl_o.to_reg = 1'b1; end
         OP_BSET: begin res_o = bset; ctl_o.wr = 1'b1; ctl_o.to_reg = 1'b1; end
         OP_BTSC: begin res_o = r_i; ctl_o.skip = ~bitv; end
         OP_BTSS: begin res_o = r_i; ctl_o.skip = bitv; end
         OP_LDI: begin res_o = imm_i; ctl_o.wr = 1'b1; end
         OP_STW: begin res_o = w_i; ctl_o.wr = 1'b1; ctl_o.to_reg = 1'b1; end
         default: ;
      endcase
      ctl_o.c  = c_sel;
      ctl_o.hc = ctl_o.hc_upd & hcout;
      ctl_o.z  = ctl_o.z_upd & (res_o == '0);
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import accalu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int HC_BIT  = 4,
   parameter int RIPPLE  = 0,
   parameter int REG_OUT = 1,
   localparam int BIT_W  = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [5:0]       op_i,
   input  logic             tgt_i,
   input  logic [WIDTH-1:0] w_i,
   input  logic [WIDTH-1:0] r_i,
   input  logic [WIDTH-1:0] imm_i,
   input  logic [BIT_W-1:0] bit_i,
   input  logic             c_i,
   output logic             out_valid,
   output logic [WIDTH-1:0] res_o,
   output logic             wr_o,
   output logic             to_reg_o,
   output logic             c_o,
   output logic             hc_o,
   output logic             z_o,
   output logic             c_upd_o,
   output logic             hc_upd_o,
   output logic             z_upd_o,
   output logic             skip_o
);

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("acc_alu: WIDTH must be even and at least 4");
      end
      if (HC_BIT < 1 || HC_BIT >= WIDTH) begin : g_bad_hc
         $error("acc_alu: HC_BIT must lie inside the data word");
      end
   endgenerate

   logic [WIDTH-1:0] res_c, res_q;
   ctl_t             ctl_c, ctl_q;
   logic             vld_q;

   alu_core #(.WIDTH(WIDTH), .HC_BIT(HC_BIT), .RIPPLE(RIPPLE)) u_core (
      .op_i(op_i), .tgt_i(tgt_i), .w_i(w_i), .r_i(r_i), .imm_i(imm_i),
      .bit_i(bit_i), .c_i(c_i), .res_o(res_c), .ctl_o(ctl_c)
   );

   generate
      if (REG_OUT != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               res_q <= '0;
               ctl_q <= CTL_IDLE;
            end else if (in_valid) begin
               vld_q <= 1'b1;
               res_q <= res_c;
               ctl_q <= ctl_c;
            end else begin
               vld_q <= 1'b0;
               ctl_q <= CTL_IDLE;
            end
         end
      end else begin : g_comb
         assign vld_q = in_valid;
         assign res_q = res_c;
         assign ctl_q = in_valid ? ctl_c : CTL_IDLE;
      end
   endgenerate

   assign out_valid = vld_q;
   assign res_o     = res_q;
   assign wr_o      = ctl_q.wr;
   assign to_reg_o  = ctl_q.to_reg;
   assign c_o       = ctl_q.c;
   assign hc_o      = ctl_q.hc;
   assign z_o       = ctl_q.z;
   assign c_upd_o   = ctl_q.c_upd;
   assign hc_upd_o  = ctl_q.hc_upd;
   assign z_upd_o   = ctl_q.z_upd;
   assign skip_o    = ctl_q.skip;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int WIDTH   = 8,
   parameter int REG_OUT = 1,
   localparam int BIT_W  = $clog2(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [5:0]       op_i,
   input logic             tgt_i,
   input logic [WIDTH-1:0] w_i,
   input logic [WIDTH-1:0] r_i,
   input logic [WIDTH-1:0] imm_i,
   input logic [BIT_W-1:0] bit_i,
   input logic             c_i,
   input logic             out_valid,
   input logic [WIDTH-1:0] res_o,
   input logic             wr_o,
   input logic             to_reg_o,
   input logic             c_o,
   input logic             hc_o,
   input logic             z_o,
   input logic             c_upd_o,
   input logic             hc_upd_o,
   input logic             z_upd_o,
   input logic             skip_o
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   generate
      if (REG_OUT != 0) begin : g_props
         assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (out_valid == $past(in_valid)));

         assert_hc_with_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
            hc_upd_o |-> (c_upd_o && z_upd_o && wr_o));

         assert_skip_no_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
            skip_o |-> (!c_upd_o && !hc_upd_o && !z_upd_o));

         assert_imm_to_w_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(in_valid) && ($past(op_i) >= 6'd9) && ($past(op_i) <= 6'd11))
            |-> (wr_o && !to_reg_o));

         assert_carry_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && out_valid && !c_upd_o) |-> (c_o == $past(c_i)));

         assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> (!wr_o && !skip_o && !c_upd_o && !hc_upd_o && !z_upd_o));

         assert_res_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !$past(in_valid)) |-> $stable(res_o));
      end
   endgenerate

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .tgt_i(tgt_i),
   .w_i(w_i), .r_i(r_i), .imm_i(imm_i), .bit_i(bit_i), .c_i(c_i),
   .out_valid(out_valid), .res_o(res_o), .wr_o(wr_o), .to_reg_o(to_reg_o),
   .c_o(c_o), .hc_o(hc_o), .z_o(z_o), .c_upd_o(c_upd_o), .hc_upd_o(hc_upd_o),
   .z_upd_o(z_upd_o), .skip_o(skip_o)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [5:0] op_i = '0;
   logic       tgt_i = 1'b0;
   logic [7:0] w_i = '0, r_i = '0, imm_i = '0;
   logic [2:0] bit_i = '0;
   logic       c_i = 1'b0;
   logic       out_valid, wr_o, to_reg_o, c_o, hc_o, z_o;
   logic       c_upd_o, hc_upd_o, z_upd_o, skip_o;
   logic [7:0] res_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   acc_alu u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .tgt_i(tgt_i),
      .w_i(w_i), .r_i(r_i), .imm_i(imm_i), .bit_i(bit_i), .c_i(c_i),
      .out_valid(out_valid), .res_o(res_o), .wr_o(wr_o), .to_reg_o(to_reg_o),
      .c_o(c_o), .hc_o(hc_o), .z_o(z_o), .c_upd_o(c_upd_o), .hc_upd_o(hc_upd_o),
      .z_upd_o(z_upd_o), .skip_o(skip_o)
   );

   // stimulus: op t w r imm b cin | expected: res wr to_reg upd(c,hc,z) flag(c,hc,z) skip
   localparam int NV = 34;
   localparam logic [51:0] VEC [NV] = '{
      {6'd0, 1'b1,8'h0F,8'h01,8'h00,3'd0,1'b0, 8'h10,1'b1,1'b1,3'b111,3'b010,1'b0},
      {6'd0, 1'b0,8'hFF,8'h01,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b111,3'b111,1'b0},
      {6'd0, 1'b0,8'h80,8'h80,8'h00,3'd0,1'b1, 8'h00,1'b1,1'b0,3'b111,3'b101,1'b0},
      {6'd1, 1'b1,8'h01,8'h03,8'h00,3'd0,1'b0, 8'h02,1'b1,1'b1,3'b111,3'b110,1'b0},
      {6'd1, 1'b0,8'h05,8'h03,8'h00,3'd0,1'b1, 8'hFE,1'b1,1'b0,3'b111,3'b000,1'b0},
      {6'd1, 1'b0,8'h00,8'h00,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b111,3'b111,1'b0},
      {6'd2, 1'b1,8'h00,8'hFF,8'h00,3'd0,1'b1, 8'h00,1'b1,1'b1,3'b001,3'b101,1'b0},
      {6'd3, 1'b0,8'h00,8'h01,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b001,3'b001,1'b0},
      {6'd4, 1'b1,8'h00,8'hFF,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b1,3'b000,3'b000,1'b1},
      {6'd5, 1'b1,8'h00,8'h05,8'h00,3'd0,1'b0, 8'h04,1'b1,1'b1,3'b000,3'b000,1'b0},
      {6'd5, 1'b0,8'h00,8'h01,8'h00,3'd0,1'b1, 8'h00,1'b1,1'b0,3'b000,3'b100,1'b1},
      {6'd6, 1'b0,8'hF0,8'h0F,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b001,3'b001,1'b0},
      {6'd7, 1'b1,8'hA0,8'h05,8'h00,3'd0,1'b0, 8'hA5,1'b1,1'b1,3'b001,3'b000,1'b0},
      {6'd8, 1'b1,8'hFF,8'h0F,8'h00,3'd0,1'b0, 8'hF0,1'b1,1'b1,3'b001,3'b000,1'b0},
      {6'd11,1'b1,8'h55,8'h00,8'h55,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b001,3'b001,1'b0},
      {6'd9, 1'b1,8'hC3,8'h00,8'h0F,3'd0,1'b0, 8'h03,1'b1,1'b0,3'b001,3'b000,1'b0},
      {6'd10,1'b0,8'h80,8'hFF,8'h01,3'd0,1'b0, 8'h81,1'b1,1'b0,3'b001,3'b000,1'b0},
      {6'd12,1'b1,8'h00,8'hFF,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b1,3'b001,3'b001,1'b0},
      {6'd13,1'b1,8'h00,8'h01,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b1,3'b100,3'b100,1'b0},
      {6'd13,1'b0,8'h00,8'h02,8'h00,3'd0,1'b1, 8'h81,1'b1,1'b0,3'b100,3'b000,1'b0},
      {6'd14,1'b0,8'h00,8'h80,8'h00,3'd0,1'b1, 8'h01,1'b1,1'b0,3'b100,3'b100,1'b0},
      {6'd14,1'b1,8'h00,8'h41,8'h00,3'd0,1'b0, 8'h82,1'b1,1'b1,3'b100,3'b000,1'b0},
      {6'd15,1'b1,8'h00,8'h3C,8'h00,3'd0,1'b1, 8'hC3,1'b1,1'b1,3'b000,3'b100,1'b0},
      {6'd16,1'b1,8'h12,8'h34,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b001,3'b001,1'b0},
      {6'd17,1'b0,8'h12,8'h34,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b1,3'b001,3'b001,1'b0},
      {6'd18,1'b0,8'h00,8'hFF,8'h00,3'd7,1'b0, 8'h7F,1'b1,1'b1,3'b000,3'b000,1'b0},
      {6'd19,1'b0,8'h00,8'h00,8'h00,3'd0,1'b1, 8'h01,1'b1,1'b1,3'b000,3'b100,1'b0},
      {6'd20,1'b1,8'h00,8'hF7,8'h00,3'd3,1'b0, 8'hF7,1'b0,1'b0,3'b000,3'b000,1'b1},
      {6'd21,1'b0,8'h00,8'hF7,8'h00,3'd3,1'b0, 8'hF7,1'b0,1'b0,3'b000,3'b000,1'b0},
      {6'd21,1'b0,8'h00,8'h80,8'h00,3'd7,1'b0, 8'h80,1'b0,1'b0,3'b000,3'b000,1'b1},
      {6'd22,1'b0,8'h55,8'h00,8'h00,3'd0,1'b0, 8'h00,1'b1,1'b0,3'b001,3'b001,1'b0},
      {6'd23,1'b1,8'h11,8'h22,8'h9A,3'd0,1'b0, 8'h9A,1'b1,1'b0,3'b000,3'b000,1'b0},
      {6'd24,1'b0,8'h6E,8'h22,8'h00,3'd0,1'b0, 8'h6E,1'b1,1'b1,3'b000,3'b000,1'b0},
      {6'd63,1'b1,8'hFF,8'hFF,8'hFF,3'd7,1'b1, 8'h00,1'b0,1'b0,3'b000,3'b100,1'b0}
   };

   function automatic string tag_of(input logic [5:0] op);
      case (op)
         6'd0: return "R2";
         6'd1: return "R3";
         6'd2, 6'd3, 6'd4, 6'd5: return "R4";
         6'd6, 6'd7, 6'd8, 6'd9, 6'd10, 6'd11, 6'd12, 6'd22: return "R5";
         6'd13, 6'd14: return "R6";
         6'd15: return "R7";
         6'd16, 6'd17: return "R8";
         6'd18, 6'd19, 6'd23, 6'd24: return "R9";
         6'd20, 6'd21: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] op, input logic t, input logic [7:0] w,
                        input logic [7:0] r, input logic [7:0] imm,
                        input logic [2:0] b, input logic cin);
      in_valid = 1'b1; op_i = op; tgt_i = t; w_i = w; r_i = r;
      imm_i = imm; bit_i = b; c_i = cin;
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] corners [8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFE, 8'hFF};
      repeat (3) @(negedge clk);
      // R13: outputs cleared during reset
      chk("R13", "reset out_valid", int'(out_valid), 0);
      chk("R13", "reset res", int'(res_o), 0);
      chk("R13", "reset strobes",
          int'({wr_o, to_reg_o, c_upd_o, hc_upd_o, z_upd_o, skip_o, c_o, hc_o, z_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table; R11 destination covered by the to_reg column
      for (int i = 0; i < NV; i++) begin
         logic [51:0] v;
         string tg;
         v  = VEC[i];
         tg = tag_of(v[51:46]);
         drive(v[51:46], v[45], v[44:37], v[36:29], v[28:21], v[20:18], v[17]);
         chk("R1", $sformatf("vec %0d valid", i), int'(out_valid), 1);
         chk(tg, $sformatf("vec %0d res", i), int'(res_o), int'(v[16:9]));
         chk(tg, $sformatf("vec %0d wr", i), int'(wr_o), int'(v[8]));
         chk("R11", $sformatf("vec %0d to_reg", i), int'(to_reg_o), int'(v[7]));
         chk(tg, $sformatf("vec %0d upd", i), int'({c_upd_o, hc_upd_o, z_upd_o}), int'(v[6:4]));
         chk(tg, $sformatf("vec %0d flags", i), int'({c_o, hc_o, z_o}), int'(v[3:1]));
         chk(tg, $sformatf("vec %0d skip", i), int'(skip_o), int'(v[0]));
      end

      // R13: idle cycle after a skipping, writing operation
      drive(6'd4, 1'b1, 8'h00, 8'hFF, 8'h00, 3'd0, 1'b0);
      in_valid = 1'b0; op_i = 6'd0; r_i = 8'h55;
      @(negedge clk);
      chk("R13", "idle out_valid", int'(out_valid), 0);
      chk("R13", "idle strobes", int'({wr_o, skip_o, c_upd_o, hc_upd_o, z_upd_o}), 0);
      chk("R13", "idle res hold", int'(res_o), 0);

      // R2 / R3: corner sweep against arithmetic model
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            int wv, rv, s, h;
            wv = int'(corners[a]);
            rv = int'(corners[b]);
            drive(6'd0, 1'b0, corners[a], corners[b], 8'h00, 3'd0, 1'b1);
            s = wv + rv;
            h = ((wv % 16) + (rv % 16)) >= 16 ? 1 : 0;
            chk("R2", $sformatf("add %0h+%0h res", wv, rv), int'(res_o), s % 256);
            chk("R2", $sformatf("add %0h+%0h c,hc,z", wv, rv), int'({c_o, hc_o, z_o}),
                ((s >= 256) ? 4 : 0) + h * 2 + ((s % 256) == 0 ? 1 : 0));
            drive(6'd1, 1'b0, corners[a], corners[b], 8'h00, 3'd0, 1'b0);
            s = rv + (255 - wv) + 1;
            h = ((rv % 16) + (15 - (wv % 16)) + 1) >= 16 ? 1 : 0;
            chk("R3", $sformatf("sub %0h-%0h res", rv, wv), int'(res_o), (rv - wv + 256) % 256);
            chk("R3", $sformatf("sub %0h-%0h c,hc,z", rv, wv), int'({c_o, hc_o, z_o}),
                ((rv >= wv) ? 4 : 0) + h * 2 + ((rv == wv) ? 1 : 0));
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule